// File: doc/BRIEF.md
# Match-Capture Timer/Counter

This block is a 32-bit timer/counter that sits behind a plain word-addressed register port. In timer mode a programmable prescaler divides the clock and each prescaler wrap advances the main count. In counter mode the prescaler is bypassed, and the count advances on rising, falling or both edges of one chosen capture pin. Both capture pins are brought into the clock domain through a two-flop synchroniser.

Four match channels compare the count against their own value registers. For each channel, software chooses whether a match raises an interrupt flag, returns the count to zero, or halts the counter. Each channel also drives a match output pin: on a match the pin is left alone, driven low, driven high or toggled. Two capture channels copy the count into their own registers on selected pin edges. Pending events are kept in a flag register that software clears by writing ones. The interrupt line is the OR of the pending flags whose enables are set.

Top module: `mct_timer`

## Requirements
- R1: After reset every register reads 0, and `irq` and `mat_out` are 0.
- R2: Word addresses are: 0 flags, 1 control, 2 count, 3 prescale limit, 4 prescale count, 5 match control, 6 to 9 match values 0 to 3, 10 capture control, 11 and 12 capture values 0 and 1, 13 match pins, 14 count control. `bus_rdata` shows the register at `bus_addr` one clock later. Only the defined bits take writes: control keeps bits 1:0, match control 0xFFF, capture control 0x3F, count control 0xF and match pins 0xFFF.
- R3: In timer mode (count control bits 1:0 = 0), while control bit 0 is set and bit 1 is clear, the prescale count steps from 0 up to the prescale limit. On the clock where it equals the limit it returns to 0 and the count advances by one. Any change of the count is either +1 or a return to 0.
- R4: While control bit 1 is set, the count and the prescale count are held at 0.
- R5: A match on channel n happens when the count advances while it equals match value n. It sets flag bit n only if match control bit 3n is set.
- R6: If match control bit 3n+1 is set, a match on channel n loads 0 into the count instead of count+1.
- R7: If match control bit 3n+2 is set, a match on channel n clears control bit 0 and the count keeps its value. This wins over a write to the control register in the same clock.
- R8: Match pin register bits 3:0 drive `mat_out`. The 2-bit field at bits 2n+5:2n+4 selects what a match on channel n does to pin n: 0 keep, 1 low, 2 high, 3 toggle.
- R9: When several channels match in the same clock, all of their flags, pin actions and zero/halt actions take effect together.
- R10: Capture pins pass through two sync flops. Capture control bit 3n selects the rising edge of pin n, bit 3n+1 the falling edge, and both bits together select either edge. On a selected edge, capture value n loads the count and flag bit 4+n is set if capture control bit 3n+2 is set.
- R11: Writing 1 to a flag bit clears it. Writing 0 has no effect. A new event in the same clock wins over the clear.
- R12: Count control modes 1, 2 and 3 advance the count on rising, falling or both edges of capture pin 0 or 1, chosen by count control bits 3:2 (0 or 1). In these modes the prescaler is bypassed and stays at 0.
- R13: `irq` is registered. It equals the OR of the flags whose enables (match control bit 3n, capture control bit 3n+2) are set, one clock after the flags change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe for `bus_addr`/`bus_wdata` |
| bus_addr | input | 4 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data, one clock after `bus_addr` |
| cap_in | input | 2 | Asynchronous capture / count pins |
| mat_out | output | 4 | Match pins |
| irq | output | 1 | Registered interrupt request |

## Verification
The assertions assume that `bus_wdata` and `bus_addr` are stable whenever `bus_wr` is high. They also assume that the clock after reset starts from the cleared register state, so the step and hold properties see only values the block itself produced. The stimulus keeps each capture pin level for at least three clocks, so the synchroniser turns every toggle into exactly one edge pulse. Bus writes are issued one per clock, away from the active edge. Control writes that start and stop the count are placed at known clocks, so the expected count, capture values and pin states come from plain edge counting.

// File: rtl/mct_pkg.sv
`timescale 1ns/1ps
package mct_pkg;
  // fixed part of the register map; array windows follow A_MV0
  localparam int unsigned A_FLAGS = 0;
  localparam int unsigned A_CTRL  = 1;
  localparam int unsigned A_COUNT = 2;
  localparam int unsigned A_PRLIM = 3;
  localparam int unsigned A_PRCNT = 4;
  localparam int unsigned A_MCTL  = 5;
  localparam int unsigned A_MV0   = 6;

  typedef enum logic [1:0] {
    PIN_KEEP = 2'd0,
    PIN_LOW  = 2'd1,
    PIN_HIGH = 2'd2,
    PIN_FLIP = 2'd3
  } pin_act_e;

  typedef enum logic [1:0] {
    CM_TIMER = 2'd0,
    CM_RISE  = 2'd1,
    CM_FALL  = 2'd2,
    CM_BOTH  = 2'd3
  } cnt_mode_e;
endpackage

// File: rtl/mct_edge_sync.sv
`timescale 1ns/1ps
module mct_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] chain_q;
  logic              last_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain_q <= '0;
      last_q  <= 1'b0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], pin};
      last_q  <= chain_q[STAGES-1];
    end
  end

  assign rise = chain_q[STAGES-1] & ~last_q;
  assign fall = ~chain_q[STAGES-1] & last_q;
endmodule

// File: rtl/mct_prescale.sv
`timescale 1ns/1ps
module mct_prescale #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         run,
  input  logic         clr,
  input  logic [W-1:0] limit,
  output logic         tick,
  output logic [W-1:0] count
);
  logic [W-1:0] cnt_q;

  assign tick  = run && (cnt_q >= limit);
  assign count = cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clr)  cnt_q <= '0;
    else if (run)    cnt_q <= tick ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/mct_match_chan.sv
`timescale 1ns/1ps
module mct_match_chan
  import mct_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] count,
  input  logic [W-1:0] value,
  input  logic         tick,
  input  logic [2:0]   cfg,
  input  logic [1:0]   act,
  input  logic         pin_base,
  output logic         evt,
  output logic         flag_set,
  output logic         zero_req,
  output logic         halt_req,
  output logic         pin_next
);
  assign evt      = tick && (count == value);
  assign flag_set = evt & cfg[0];
  assign zero_req = evt & cfg[1];
  assign halt_req = evt & cfg[2];

  always_comb begin
    pin_next = pin_base;
    if (evt) begin
      case (pin_act_e'(act))
        PIN_LOW:  pin_next = 1'b0;
        PIN_HIGH: pin_next = 1'b1;
        PIN_FLIP: pin_next = ~pin_base;
        default:  pin_next = pin_base;
      endcase
    end
  end
endmodule

// File: rtl/mct_timer.sv
`timescale 1ns/1ps
module mct_timer
  import mct_pkg::*;
#(
  parameter int W  = 32,
  parameter int NM = 4,
  parameter int NC = 2,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [W-1:0]  bus_wdata,
  output logic [W-1:0]  bus_rdata,
  input  logic [NC-1:0] cap_in,
  output logic [NM-1:0] mat_out,
  output logic          irq
);
  localparam int MCW    = 3 * NM;
  localparam int CCW    = 3 * NC;
  localparam int FLW    = NM + NC;
  localparam int SELW   = (NC > 1) ? $clog2(NC) : 1;
  localparam int unsigned A_CCTL   = A_MV0 + NM;
  localparam int unsigned A_CV0    = A_CCTL + 1;
  localparam int unsigned A_EXT    = A_CV0 + NC;
  localparam int unsigned A_CNTCTL = A_EXT + 1;

  // register state
  logic             run_q, zero_q;
  logic [W-1:0]     tc_q, pr_q;
  logic [MCW-1:0]   mctl_q;
  logic [W-1:0]     mv_q [NM];
  logic [CCW-1:0]   cctl_q;
  logic [W-1:0]     cv_q [NC];
  logic [NM-1:0]    ext_state_q;
  logic [2*NM-1:0]  ext_act_q;
  logic [3:0]       cntctl_q;
  logic [FLW-1:0]   flags_q;
  logic [W-1:0]     rdata_q;
  logic             irq_q;

  // write decodes
  logic wr_flags, wr_ctrl, wr_prlim, wr_mctl, wr_cctl, wr_ext, wr_cntctl;
  assign wr_flags  = bus_wr && (bus_addr == AW'(A_FLAGS));
  assign wr_ctrl   = bus_wr && (bus_addr == AW'(A_CTRL));
  assign wr_prlim  = bus_wr && (bus_addr == AW'(A_PRLIM));
  assign wr_mctl   = bus_wr && (bus_addr == AW'(A_MCTL));
  assign wr_cctl   = bus_wr && (bus_addr == AW'(A_CCTL));
  assign wr_ext    = bus_wr && (bus_addr == AW'(A_EXT));
  assign wr_cntctl = bus_wr && (bus_addr == AW'(A_CNTCTL));

  // count source selection
  logic [NC-1:0] rise_v, fall_v;
  logic          timer_mode, ps_tick, cnt_edge, tick, active;
  logic [W-1:0]  pc;
  logic [SELW-1:0] sel_idx;

  assign timer_mode = (cnt_mode_e'(cntctl_q[1:0]) == CM_TIMER);
  assign active     = run_q && !zero_q;
  assign sel_idx    = cntctl_q[2 +: SELW];

  always_comb begin
    case (cnt_mode_e'(cntctl_q[1:0]))
      CM_RISE: cnt_edge = rise_v[sel_idx];
      CM_FALL: cnt_edge = fall_v[sel_idx];
      CM_BOTH: cnt_edge = rise_v[sel_idx] | fall_v[sel_idx];
      default: cnt_edge = 1'b0;
    endcase
  end

  mct_prescale #(.W(W)) u_ps (
    .clk   (clk),
    .rst   (rst),
    .run   (active && timer_mode),
    .clr   (zero_q),
    .limit (pr_q),
    .tick  (ps_tick),
    .count (pc)
  );

  assign tick = active && (timer_mode ? ps_tick : cnt_edge);

  // match channels
  logic [NM-1:0]  match_evt_v, mflag_v, zreq_v, hreq_v, pin_next_v, ext_base;
  logic [FLW-1:0] int_en_v, set_vec;
  logic           zero_any, stop_any;

  assign ext_base = wr_ext ? bus_wdata[NM-1:0] : ext_state_q;

  for (genvar n = 0; n < NM; n++) begin : g_match
    mct_match_chan #(.W(W)) u_ch (
      .count    (tc_q),
      .value    (mv_q[n]),
      .tick     (tick),
      .cfg      (mctl_q[3*n +: 3]),
      .act      (ext_act_q[2*n +: 2]),
      .pin_base (ext_base[n]),
      .evt      (match_evt_v[n]),
      .flag_set (mflag_v[n]),
      .zero_req (zreq_v[n]),
      .halt_req (hreq_v[n]),
      .pin_next (pin_next_v[n])
    );
    assign int_en_v[n] = mctl_q[3*n];
  end

  assign zero_any = |zreq_v;
  assign stop_any = |hreq_v;

  // capture channels
  logic [NC-1:0] cap_evt_v, cflag_v;

  for (genvar n = 0; n < NC; n++) begin : g_cap
    logic [W-1:0] hold_q;
    mct_edge_sync #(.STAGES(2)) u_sync (
      .clk  (clk),
      .rst  (rst),
      .pin  (cap_in[n]),
      .rise (rise_v[n]),
      .fall (fall_v[n])
    );
    assign cap_evt_v[n]     = (rise_v[n] & cctl_q[3*n]) | (fall_v[n] & cctl_q[3*n+1]);
    assign cflag_v[n]       = cap_evt_v[n] & cctl_q[3*n+2];
    assign int_en_v[NM + n] = cctl_q[3*n+2];
    always_ff @(posedge clk) begin
      if (rst)               hold_q <= '0;
      else if (cap_evt_v[n]) hold_q <= tc_q;
    end
    assign cv_q[n] = hold_q;
  end

  assign set_vec = {cflag_v, mflag_v};

  // control, counter and configuration registers
  always_ff @(posedge clk) begin
    if (rst) begin
      run_q       <= 1'b0;
      zero_q      <= 1'b0;
      tc_q        <= '0;
      pr_q        <= '0;
      mctl_q      <= '0;
      cctl_q      <= '0;
      ext_state_q <= '0;
      ext_act_q   <= '0;
      cntctl_q    <= '0;
      flags_q     <= '0;
      irq_q       <= 1'b0;
      for (int i = 0; i < NM; i++) mv_q[i] <= '0;
    end else begin
      if (wr_ctrl) begin
        run_q  <= bus_wdata[0];
        zero_q <= bus_wdata[1];
      end
      if (stop_any) run_q <= 1'b0;

      if (zero_q)        tc_q <= '0;
      else if (tick) begin
        if (zero_any)      tc_q <= '0;
        else if (!stop_any) tc_q <= tc_q + 1'b1;
      end

      if (wr_prlim)  pr_q     <= bus_wdata;
      if (wr_mctl)   mctl_q   <= bus_wdata[MCW-1:0];
      if (wr_cctl)   cctl_q   <= bus_wdata[CCW-1:0];
      if (wr_cntctl) cntctl_q <= bus_wdata[3:0];
      if (wr_ext)    ext_act_q <= bus_wdata[NM +: 2*NM];
      ext_state_q <= pin_next_v;

      for (int i = 0; i < NM; i++)
        if (bus_wr && (bus_addr == AW'(A_MV0 + i))) mv_q[i] <= bus_wdata;

      flags_q <= (flags_q & ~(wr_flags ? bus_wdata[FLW-1:0] : '0)) | set_vec;
      irq_q   <= |(flags_q & int_en_v);
    end
  end

  // read port
  logic [W-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    case (bus_addr)
      AW'(A_FLAGS):  rd_mux = W'(flags_q);
      AW'(A_CTRL):   rd_mux = W'({zero_q, run_q});
      AW'(A_COUNT):  rd_mux = tc_q;
      AW'(A_PRLIM):  rd_mux = pr_q;
      AW'(A_PRCNT):  rd_mux = pc;
      AW'(A_MCTL):   rd_mux = W'(mctl_q);
      AW'(A_CCTL):   rd_mux = W'(cctl_q);
      AW'(A_EXT):    rd_mux = W'({ext_act_q, ext_state_q});
      AW'(A_CNTCTL): rd_mux = W'(cntctl_q);
      default:       rd_mux = '0;
    endcase
    for (int i = 0; i < NM; i++)
      if (bus_addr == AW'(A_MV0 + i)) rd_mux = mv_q[i];
    for (int i = 0; i < NC; i++)
      if (bus_addr == AW'(A_CV0 + i)) rd_mux = cv_q[i];
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else     rdata_q <= rd_mux;
  end

  assign bus_rdata = rdata_q;
  assign mat_out   = ext_state_q;
  assign irq       = irq_q;
endmodule

// File: rtl/mct_timer_chk.sv
`timescale 1ns/1ps
module mct_timer_chk #(
  parameter int W  = 32,
  parameter int NM = 4,
  parameter int NC = 2,
  parameter int AW = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          bus_wr,
  input logic [AW-1:0] bus_addr,
  input logic [W-1:0]  bus_wdata,
  input logic          irq,
  input logic [NM-1:0] mat_out,
  input logic [W-1:0]  tc,
  input logic [NM+NC-1:0] flags,
  input logic          run,
  input logic          zero,
  input logic          stop_any,
  input logic [NM-1:0] match_evt,
  input logic [NM+NC-1:0] flag_set
);
  localparam int FLW = NM + NC;
  localparam int unsigned A_FL  = 0;
  localparam int unsigned A_EXT = 6 + NM + 1 + NC;

  // R4: control reset bit forces the count to zero
  a_r4_zero_holds: assert property (@(posedge clk) disable iff (rst)
    zero |=> (tc == '0)) else $error("a_r4_zero_holds");

  // R7: a halting match clears the run bit
  a_r7_stop_halts: assert property (@(posedge clk) disable iff (rst)
    stop_any |=> !run) else $error("a_r7_stop_halts");

  // R3: the count only steps by one or returns to zero
  a_r3_count_step: assert property (@(posedge clk) disable iff (rst)
    !$stable(tc) |-> ((tc == $past(tc) + 1'b1) || (tc == '0))) else $error("a_r3_count_step");

  // R13: with no pending flag the request is low next clock
  a_r13_quiet_irq: assert property (@(posedge clk) disable iff (rst)
    (flags == '0) |=> !irq) else $error("a_r13_quiet_irq");

  // R11: writing all ones with no new event empties the flags
  a_r11_w1c_all: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && (bus_addr == AW'(A_FL)) && (&bus_wdata[FLW-1:0]) && (flag_set == '0))
    |=> (flags == '0)) else $error("a_r11_w1c_all");

  // R8: pins move only on a match or a pin register write
  a_r8_pins_hold: assert property (@(posedge clk) disable iff (rst)
    ((match_evt == '0) && !(bus_wr && (bus_addr == AW'(A_EXT)))) |=> $stable(mat_out))
    else $error("a_r8_pins_hold");
endmodule

bind mct_timer mct_timer_chk #(.W(W), .NM(NM), .NC(NC), .AW(AW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .irq       (irq),
  .mat_out   (mat_out),
  .tc        (tc_q),
  .flags     (flags_q),
  .run       (run_q),
  .zero      (zero_q),
  .stop_any  (stop_any),
  .match_evt (match_evt_v),
  .flag_set  (set_vec)
);

// File: tb/sim_mct_timer.sv
`timescale 1ns/1ps
module sim_mct_timer;
  localparam logic [3:0] FL = 0, CT = 1, CN = 2, PL = 3, PC = 4, MC = 5, MV0 = 6,
                         MV1 = 7, MV2 = 8, CC = 10, CV0 = 11, CV1 = 12, EX = 13, KC = 14;
  localparam int K_RD = 0, K_IRQ = 1, K_MAT = 2;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [1:0]  cap_in = '0;
  logic [3:0]  mat_out;
  logic        irq;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 0;

  typedef struct {
    int          kind;
    logic [31:0] exp;
    string       tag;
    int          due;
  } item_t;
  item_t sb[$];

  mct_timer u0 (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .cap_in(cap_in), .mat_out(mat_out), .irq(irq)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // monitor: pops expected items once their clock has passed
  initial begin
    forever begin
      @(negedge clk);
      if (sb.size() > 0 && sb[0].due < cyc) begin
        item_t it;
        logic [31:0] act;
        it = sb.pop_front();
        case (it.kind)
          K_IRQ:   act = {31'b0, irq};
          K_MAT:   act = {28'b0, mat_out};
          default: act = bus_rdata;
        endcase
        checks++;
        if (act !== it.exp) begin
          errors++;
          $display("FAIL %s actual=%0h expected=%0h", it.tag, act, it.exp);
        end
      end
    end
  end

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic expect_item(input int kind, input logic [3:0] a, input logic [31:0] e, input string tag);
    item_t it;
    if (kind == K_RD) bus_addr = a;
    it.kind = kind; it.exp = e; it.tag = tag; it.due = cyc;
    sb.push_back(it);
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic flip(input int ch);
    cap_in[ch] = ~cap_in[ch];
    idle(3);
  endtask

  task automatic zero_count();
    wr(CT, 32'h2); idle(1); wr(CT, 32'h0);
  endtask

  initial begin
    idle(4);
    rst = 1'b0;
    idle(1);

    // R1 reset state
    expect_item(K_RD, FL, 0, "R1 flags");
    expect_item(K_RD, CT, 0, "R1 control");
    expect_item(K_RD, CN, 0, "R1 count");
    expect_item(K_IRQ, 0, 0, "R1 irq");
    expect_item(K_MAT, 0, 0, "R1 mat_out");

    // R2 write masks
    wr(MC, 32'hFFFF_FFFF); expect_item(K_RD, MC, 32'hFFF, "R2 match control mask");
    wr(CC, 32'hFFFF_FFFF); expect_item(K_RD, CC, 32'h3F, "R2 capture control mask");
    wr(KC, 32'hFFFF_FFFF); expect_item(K_RD, KC, 32'hF, "R2 count control mask");
    wr(EX, 32'hFFFF_F000); expect_item(K_RD, EX, 32'h0, "R2 pin register mask");
    wr(MC, 0); wr(CC, 0); wr(KC, 0);
    wr(CT, 32'hFFFF_FFFE); expect_item(K_RD, CT, 32'h2, "R2 control mask");
    wr(CT, 0);

    // R3 prescaled timer: limit 2, 8 running clocks -> count 2, prescale 2
    wr(PL, 2);
    wr(CT, 1); idle(7); wr(CT, 0);
    expect_item(K_RD, CN, 2, "R3 count after 8 clocks");
    expect_item(K_RD, PC, 2, "R3 prescale count");

    // R4 zeroing bit
    wr(CT, 2); idle(1);
    expect_item(K_RD, CN, 0, "R4 count held at zero");
    expect_item(K_RD, PC, 0, "R4 prescale held at zero");
    wr(CT, 0);

    // R5 R6 R8: value 4, flag+zero, toggle pin 0; 7 ticks -> count 2
    wr(PL, 0); wr(MV0, 4); wr(MC, 32'h3); wr(EX, 32'h30);
    wr(CT, 1); idle(6); wr(CT, 0);
    expect_item(K_RD, CN, 2, "R6 count restarted after match");
    expect_item(K_RD, FL, 1, "R5 match flag 0");
    expect_item(K_MAT, 0, 1, "R8 toggle pin 0");
    expect_item(K_IRQ, 0, 1, "R13 irq from match flag");

    // R11 write-one-to-clear
    wr(FL, 32'h3E); expect_item(K_RD, FL, 1, "R11 zeros do not clear");
    wr(FL, 32'h01); expect_item(K_RD, FL, 0, "R11 one clears");
    expect_item(K_IRQ, 0, 0, "R13 irq drops with flag");

    // R7 R9: channels 1 and 2 at 3, ch1 halts and drives high, ch2 drives low
    zero_count();
    wr(MV1, 3); wr(MV2, 3); wr(MC, 32'h68); wr(EX, 32'h185);
    wr(CT, 1); idle(8);
    expect_item(K_RD, CT, 0, "R7 run bit cleared");
    expect_item(K_RD, CN, 3, "R7 count held at match");
    expect_item(K_RD, FL, 6, "R9 both flags");
    expect_item(K_MAT, 0, 3, "R9 both pin actions");

    // R10 capture: pin0 rising with flag, pin1 falling without flag
    cap_in[1] = 1'b1;
    zero_count();
    wr(FL, 32'h3F); wr(MC, 0); wr(EX, 0); wr(CC, 32'h15);
    wr(CT, 1);
    cap_in[0] = 1'b1;
    idle(3);
    cap_in[1] = 1'b0;
    idle(5);
    wr(CT, 0);
    expect_item(K_RD, CV0, 2, "R10 rising capture value");
    expect_item(K_RD, CV1, 5, "R10 falling capture value");
    expect_item(K_RD, FL, 32'h10, "R10 capture flag only for enabled channel");
    expect_item(K_IRQ, 0, 1, "R13 irq from capture flag");
    wr(CC, 32'h1);
    expect_item(K_IRQ, 0, 0, "R13 disabled enable masks pending flag");
    expect_item(K_RD, FL, 32'h10, "R13 flag still pending");

    // R12 counter mode: both edges of pin 1, prescaler bypassed
    zero_count();
    wr(FL, 32'h3F); wr(CC, 0); wr(PL, 5); wr(KC, 32'h7);
    wr(CT, 1);
    flip(1); flip(0); flip(1); flip(0); flip(1); flip(1);
    idle(4); wr(CT, 0);
    expect_item(K_RD, CN, 4, "R12 both-edge count on pin 1");
    expect_item(K_RD, PC, 0, "R12 prescaler idle");

    // R12 rising edges of pin 1
    wr(CT, 2); idle(1); wr(KC, 32'h5); wr(CT, 1);
    flip(1); flip(1); flip(1); flip(1);
    idle(4); wr(CT, 0);
    expect_item(K_RD, CN, 2, "R12 rising count on pin 1");

    // R12 falling edges of pin 0
    wr(CT, 2); idle(1); wr(KC, 32'h2); wr(CT, 1);
    flip(0); flip(0); flip(0); flip(0);
    idle(4); wr(CT, 0);
    expect_item(K_RD, CN, 2, "R12 falling count on pin 0");

    idle(4);
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule